// File: doc/BRIEF.md
# Host-Slave Data Bus Buffer

This block is a two-channel mailbox between an external master processor bus and the register port of an internal slave processor. Each channel holds the following registers:

- an inbound byte, written by the master;
- an outbound byte, written by the slave;
- a status byte;
- a control byte.

Full flags in the status byte form the handshake. The side that fills a buffer sets its flag, and the side that drains it clears the flag. On each master write, the level of the master's A0 line is captured into the status byte. This lets slave firmware tell a command byte (A0 high) from a data byte (A0 low).

The master side has the following signals:

- an 8-bit data bus with an output enable;
- one active-low select per channel;
- an A0 line;
- two strobe pins.

Each channel's control byte decides how the strobe pins are read. One style uses separate read and write strobes. The other uses a single read/write direction line, with the select acting as the strobe. All master pins are synchronised to the slave clock. Each access takes effect once, when its strobe ends.

The slave side is a plain register port. It has a channel number, a 2-bit register address, and read and write enables. Per channel, the block drives two interrupt pulses: one when the input buffer fills and one when the output buffer empties. It also drives two flag outputs that can be switched on.

Top module: `hmbx_top`

## Requirements
- R1: After reset, every channel's status and control bytes read 0x00. All flag outputs and interrupt outputs are low, and `h_doe` is low.
- R2: A slave write to register address 0 loads the outbound byte and sets status bit 0 (output full). A master read with A0 low returns the outbound byte, and the end of that read clears status bit 0.
- R3: A master write loads the inbound byte, sets status bit 1 (input full) and copies the A0 level into status bit 3. A slave read of register address 0 returns the inbound byte and clears status bit 1.
- R4: A master read with A0 high returns the status byte and leaves status bit 0 unchanged.
- R5: Status bits 2, 4, 5, 6 and 7 are written by the slave at register address 1 and are seen by both sides. Slave writes to status bits 0, 1 and 3 have no effect.
- R6: The control byte sits at register address 2. Its bit 5 always reads 0.
- R7: `irq_ibf` pulses for one cycle when a master write completes, unless control bit 4 is 1. When control bit 2 is 1, only writes with A0 high raise the pulse.
- R8: `irq_obe` pulses for one cycle when a master read with A0 low clears a set output-full flag, unless control bit 3 is 1.
- R9: Control bit 7 selects the strobe style. With 0, `h_rd_n` and `h_wr_n` are separate active-low strobes. With 1, `h_rd_n` is a direction line (high = read, low = write) and the channel select is the strobe.
- R10: While control bit 6 is 0, master accesses to that channel are ignored: no register or flag changes, and `h_doe` stays low.
- R11: `obf_o` shows the output-full flag when control bit 0 is 1, and `ibf_o` shows the input-full flag when control bit 1 is 1. Otherwise each reads 0.
- R12: The channels are independent. The slave port reaches the channel given by `s_ch`, and register address 3 reads 0x00.
- R13: `h_doe` and the read data appear after the second rising clock edge following the strobe's leading edge. Flags, registers and interrupt pulses change on the third rising edge following the strobe's trailing edge.
- R14: If a slave write at address 0 lands in the same cycle as a master read clearing output-full, the flag ends at 1. If a slave read at address 0 lands in the same cycle as a master write, input-full ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs_n | input | NCH | Master select per channel, active low |
| h_rd_n | input | 1 | Read strobe, or direction line in combined style |
| h_wr_n | input | 1 | Write strobe in separate style |
| h_a0 | input | 1 | Master address line: 1 = status/command, 0 = data |
| h_din | input | 8 | Master write data |
| h_dout | output | 8 | Master read data |
| h_doe | output | 1 | Master data bus drive enable |
| s_ch | input | CHW | Slave channel number |
| s_addr | input | 2 | Slave register address: 0 data, 1 status, 2 control |
| s_we | input | 1 | Slave write enable |
| s_re | input | 1 | Slave read enable (read of address 0 drains input) |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data, combinational |
| obf_o | output | NCH | Output-full flag pins |
| ibf_o | output | NCH | Input-full flag pins |
| irq_obe | output | NCH | Output-empty interrupt pulse |
| irq_ibf | output | NCH | Input-full interrupt pulse |

## Verification
Slave-port effects land on the first rising edge after the enables are driven, and slave read data is combinational. Master pins pass two synchroniser stages. The drive enable and read data are therefore sampled at the falling edge after the second rising edge from the strobe's start, with a check one cycle earlier that they are still low. Register, flag and interrupt effects of a master access are due on the third rising edge after the strobe ends. The reference model updates right after that edge, and the flag and interrupt pins are compared with the model at every falling edge. Collision cases drive the slave access so that it meets the master's effect on that same third edge.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    localparam int DW = 8;

    // status byte positions the master side decodes
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_A0  = 3;

    localparam logic [DW-1:0] USER_MASK = 8'hF4;
    localparam logic [DW-1:0] CTRL_MASK = 8'hDF;

    typedef struct packed {
        logic rw_style;
        logic bus_en;
        logic rsvd;
        logic ibf_irq_off;
        logic obe_irq_off;
        logic ibf_cmd_only;
        logic ibf_pin_en;
        logic obf_pin_en;
    } hmbx_ctrl_t;

    typedef enum logic [1:0] {
        SREG_DATA = 2'd0,
        SREG_STAT = 2'd1,
        SREG_CTRL = 2'd2,
        SREG_NONE = 2'd3
    } hmbx_sreg_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } hmbx_acc_t;

    function automatic hmbx_acc_t decode_acc(logic rw_style, logic cs_n,
                                              logic rd_n, logic wr_n);
        hmbx_acc_t a;
        if (rw_style) begin
            a.rd = !cs_n && rd_n;
            a.wr = !cs_n && !rd_n;
        end else begin
            a.rd = !cs_n && !rd_n;
            a.wr = !cs_n && !wr_n && rd_n;
        end
        return a;
    endfunction

    function automatic logic [DW-1:0] pack_status(logic [DW-1:0] user, logic a0f,
                                                   logic ibf, logic obf);
        logic [DW-1:0] s;
        s = user & USER_MASK;
        s[ST_OBF] = obf;
        s[ST_IBF] = ibf;
        s[ST_A0]  = a0f;
        return s;
    endfunction

endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
    parameter int W = 12,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_st
            logic [W-1:0] r;
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= g_st[i-1].r;
                end
            end
        end
    endgenerate

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/hmbx_host_if.sv
module hmbx_host_if
    import hmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  hmbx_ctrl_t    ctrl,
    input  logic          cs_n_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          a0_s,
    input  logic [DW-1:0] din_s,
    output logic          rd_active,
    output logic          rd_done,
    output logic          wr_done,
    output logic          a0_held,
    output logic [DW-1:0] data_held
);
    hmbx_acc_t acc, acc_q;

    always_comb begin
        acc = decode_acc(ctrl.rw_style, cs_n_s, rd_n_s, wr_n_s);
        if (!ctrl.bus_en) acc = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            a0_held   <= 1'b0;
            data_held <= '0;
        end else begin
            acc_q <= acc;
            if (acc.rd || acc.wr) a0_held <= a0_s;
            if (acc.wr)           data_held <= din_s;
        end
    end

    assign rd_active = acc.rd;
    assign rd_done   = acc_q.rd && !acc.rd;
    assign wr_done   = acc_q.wr && !acc.wr;
endmodule

// File: rtl/hmbx_chan.sv
module hmbx_chan
    import hmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          s_we,
    input  logic          s_re,
    input  hmbx_sreg_e    s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    input  logic          h_rd_done,
    input  logic          h_wr_done,
    input  logic          h_a0,
    input  logic [DW-1:0] h_data,
    output logic [DW-1:0] status,
    output logic [DW-1:0] out_data,
    output hmbx_ctrl_t    ctrl,
    output logic          obf,
    output logic          ibf,
    output logic          irq_obe,
    output logic          irq_ibf
);
    logic [DW-1:0] in_q, user_q;
    logic          a0f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q     <= '0;
            out_data <= '0;
            user_q   <= '0;
            a0f_q    <= 1'b0;
            obf      <= 1'b0;
            ibf      <= 1'b0;
            ctrl     <= '0;
            irq_obe  <= 1'b0;
            irq_ibf  <= 1'b0;
        end else begin
            irq_obe <= h_rd_done && !h_a0 && obf && !ctrl.obe_irq_off;
            irq_ibf <= h_wr_done && !ctrl.ibf_irq_off && (!ctrl.ibf_cmd_only || h_a0);
            // master drain first, slave fill wins
            if (h_rd_done && !h_a0) obf <= 1'b0;
            if (s_we) begin
                case (s_addr)
                    SREG_DATA: begin
                        out_data <= s_wdata;
                        obf      <= 1'b1;
                    end
                    SREG_STAT: user_q <= s_wdata & USER_MASK;
                    SREG_CTRL: ctrl   <= hmbx_ctrl_t'(s_wdata & CTRL_MASK);
                    default: ;
                endcase
            end
            // slave drain first, master fill wins
            if (s_re && s_addr == SREG_DATA) ibf <= 1'b0;
            if (h_wr_done) begin
                in_q  <= h_data;
                ibf   <= 1'b1;
                a0f_q <= h_a0;
            end
        end
    end

    assign status = pack_status(user_q, a0f_q, ibf, obf);

    always_comb begin
        case (s_addr)
            SREG_DATA: s_rdata = in_q;
            SREG_STAT: s_rdata = status;
            SREG_CTRL: s_rdata = ctrl;
            default:   s_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hmbx_top.sv
module hmbx_top
    import hmbx_pkg::*;
#(
    parameter int NCH = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] h_cs_n,
    input  logic           h_rd_n,
    input  logic           h_wr_n,
    input  logic           h_a0,
    input  logic [DW-1:0]  h_din,
    output logic [DW-1:0]  h_dout,
    output logic           h_doe,
    input  logic [CHW-1:0] s_ch,
    input  logic [1:0]     s_addr,
    input  logic           s_we,
    input  logic           s_re,
    input  logic [DW-1:0]  s_wdata,
    output logic [DW-1:0]  s_rdata,
    output logic [NCH-1:0] obf_o,
    output logic [NCH-1:0] ibf_o,
    output logic [NCH-1:0] irq_obe,
    output logic [NCH-1:0] irq_ibf
);
    localparam int SW = NCH + 3 + DW;
    localparam logic [SW-1:0] PIN_IDLE = {{DW{1'b0}}, 1'b0, 1'b1, 1'b1, {NCH{1'b1}}};

    logic [SW-1:0]  pins_s;
    logic [NCH-1:0] cs_n_s;
    logic           rd_n_s, wr_n_s, a0_s;
    logic [DW-1:0]  din_s;

    hmbx_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({h_din, h_a0, h_wr_n, h_rd_n, h_cs_n}),
        .q   (pins_s)
    );
    assign {din_s, a0_s, wr_n_s, rd_n_s, cs_n_s} = pins_s;

    logic [NCH-1:0]           rd_act, rd_done, wr_done, a0_held;
    logic [NCH-1:0]           obf_q, ibf_q;
    logic [NCH-1:0][DW-1:0]   data_held, stat, outd, srd;
    hmbx_ctrl_t [NCH-1:0]     ctrl_q;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic sel;
            assign sel = (s_ch == CHW'(c));

            hmbx_host_if u_host (
                .clk       (clk),
                .rst       (rst),
                .ctrl      (ctrl_q[c]),
                .cs_n_s    (cs_n_s[c]),
                .rd_n_s    (rd_n_s),
                .wr_n_s    (wr_n_s),
                .a0_s      (a0_s),
                .din_s     (din_s),
                .rd_active (rd_act[c]),
                .rd_done   (rd_done[c]),
                .wr_done   (wr_done[c]),
                .a0_held   (a0_held[c]),
                .data_held (data_held[c])
            );

            hmbx_chan u_chan (
                .clk       (clk),
                .rst       (rst),
                .s_we      (s_we && sel),
                .s_re      (s_re && sel),
                .s_addr    (hmbx_sreg_e'(s_addr)),
                .s_wdata   (s_wdata),
                .s_rdata   (srd[c]),
                .h_rd_done (rd_done[c]),
                .h_wr_done (wr_done[c]),
                .h_a0      (a0_held[c]),
                .h_data    (data_held[c]),
                .status    (stat[c]),
                .out_data  (outd[c]),
                .ctrl      (ctrl_q[c]),
                .obf       (obf_q[c]),
                .ibf       (ibf_q[c]),
                .irq_obe   (irq_obe[c]),
                .irq_ibf   (irq_ibf[c])
            );

            assign obf_o[c] = obf_q[c] && ctrl_q[c].obf_pin_en;
            assign ibf_o[c] = ibf_q[c] && ctrl_q[c].ibf_pin_en;
        end
    endgenerate

    always_comb begin
        h_dout  = '0;
        s_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_act[c]) h_dout |= a0_s ? stat[c] : outd[c];
            if (s_ch == CHW'(c)) s_rdata = srd[c];
        end
    end

    assign h_doe = |rd_act;
endmodule

// File: rtl/hmbx_chk.sv
module hmbx_chk
    import hmbx_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CHW-1:0]       s_ch,
    input logic [1:0]           s_addr,
    input logic                 s_we,
    input logic [NCH-1:0]       obf_q,
    input logic [NCH-1:0]       ibf_q,
    input logic [NCH-1:0]       irq_obe,
    input logic [NCH-1:0]       irq_ibf,
    input hmbx_ctrl_t [NCH-1:0] ctrl_q
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_c
            // R2
            obf_on_fill_chk: assert property (@(posedge clk) disable iff (rst)
                (s_we && s_addr == 2'd0 && s_ch == CHW'(c)) |=> obf_q[c]);

            // R7
            ibf_irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
                irq_ibf[c] |-> ibf_q[c]);

            // R7
            ibf_irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
                irq_ibf[c] |-> $past(!ctrl_q[c].ibf_irq_off));

            // R14
            obe_irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
                irq_obe[c] |-> (!obf_q[c] ||
                    $past(s_we && s_addr == 2'd0 && s_ch == CHW'(c))));

            // R8
            obf_drain_irq_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(obf_q[c]) |-> (irq_obe[c] || $past(ctrl_q[c].obe_irq_off)));
        end
    endgenerate
endmodule

bind hmbx_top hmbx_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_ch    (s_ch),
    .s_addr  (s_addr),
    .s_we    (s_we),
    .obf_q   (obf_q),
    .ibf_q   (ibf_q),
    .irq_obe (irq_obe),
    .irq_ibf (irq_ibf),
    .ctrl_q  (ctrl_q)
);

// File: tb/test_hmbx_top.sv
`timescale 1ns/1ps
module test_hmbx_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] h_cs_n = '1;
    logic           h_rd_n = 1'b1, h_wr_n = 1'b1, h_a0 = 1'b0;
    logic [7:0]     h_din = '0;
    logic [7:0]     h_dout;
    logic           h_doe;
    logic [0:0]     s_ch = '0;
    logic [1:0]     s_addr = '0;
    logic           s_we = 1'b0, s_re = 1'b0;
    logic [7:0]     s_wdata = '0;
    logic [7:0]     s_rdata;
    logic [NCH-1:0] obf_o, ibf_o, irq_obe, irq_ibf;

    hmbx_top #(.NCH(NCH)) i_hmbx_top (
        .clk(clk), .rst(rst), .h_cs_n(h_cs_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n),
        .h_a0(h_a0), .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe),
        .s_ch(s_ch), .s_addr(s_addr), .s_we(s_we), .s_re(s_re),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .obf_o(obf_o), .ibf_o(ibf_o),
        .irq_obe(irq_obe), .irq_ibf(irq_ibf)
    );

    always #10 clk = ~clk;

    int nvec = 0, nfail = 0;
    bit run = 0;

    logic [7:0] m_out[NCH], m_in[NCH], m_user[NCH], m_ctrl[NCH];
    logic       m_obf[NCH], m_ibf[NCH], m_a0[NCH], e_obe[NCH], e_ibf[NCH];

    function automatic logic [7:0] mstat(int c);
        return {m_user[c][7:4], m_a0[c], m_user[c][2], m_ibf[c], m_obf[c]};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison of pins against the model
    always @(negedge clk) begin
        if (run) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R11 obf_o", {7'd0, obf_o[c]}, {7'd0, m_ctrl[c][0] & m_obf[c]});
                chk("R11 ibf_o", {7'd0, ibf_o[c]}, {7'd0, m_ctrl[c][1] & m_ibf[c]});
                chk("R8 irq_obe", {7'd0, irq_obe[c]}, {7'd0, e_obe[c]});
                chk("R7 irq_ibf", {7'd0, irq_ibf[c]}, {7'd0, e_ibf[c]});
            end
        end
    end

    task automatic sl_wr(int c, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        s_ch = c[0:0]; s_addr = a; s_wdata = d; s_we = 1'b1;
        @(posedge clk); #1;
        s_we = 1'b0;
        case (a)
            2'd0: begin m_out[c] = d; m_obf[c] = 1'b1; end
            2'd1: m_user[c] = d & 8'hF4;
            2'd2: m_ctrl[c] = d & 8'hDF;
            default: ;
        endcase
    endtask

    task automatic sl_rd(int c, logic [1:0] a, string tag);
        logic [7:0] exp;
        @(negedge clk);
        s_ch = c[0:0]; s_addr = a; s_re = 1'b1;
        #1;
        case (a)
            2'd0: exp = m_in[c];
            2'd1: exp = mstat(c);
            2'd2: exp = m_ctrl[c];
            default: exp = 8'h00;
        endcase
        chk(tag, s_rdata, exp);
        @(posedge clk); #1;
        s_re = 1'b0;
        if (a == 2'd0) m_ibf[c] = 1'b0;
    endtask

    task automatic host_acc(int c, bit wr, bit a0, logic [7:0] d, bit collide, string tag);
        bit en, rws;
        en  = m_ctrl[c][6];
        rws = m_ctrl[c][7];
        @(negedge clk);
        h_a0 = a0; h_din = d;
        if (rws) h_rd_n = !wr;
        else if (wr) h_wr_n = 1'b0;
        else h_rd_n = 1'b0;
        h_cs_n[c] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({tag, " R13 early doe"}, {7'd0, h_doe}, 8'd0);
        @(posedge clk); @(negedge clk);
        if (!wr) begin
            chk({tag, " doe"}, {7'd0, h_doe}, {7'd0, en});
            if (en) chk({tag, " dout"}, h_dout, a0 ? mstat(c) : m_out[c]);
        end else begin
            chk({tag, " doe on write"}, {7'd0, h_doe}, 8'd0);
        end
        @(negedge clk);
        h_cs_n[c] = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1;
        @(posedge clk); @(posedge clk);
        if (collide) begin
            @(negedge clk);
            s_ch = c[0:0]; s_addr = 2'd0;
            if (wr) s_re = 1'b1;
            else begin s_we = 1'b1; s_wdata = 8'h5A; end
        end
        @(posedge clk); #1;
        s_we = 1'b0; s_re = 1'b0;
        if (collide && wr) m_ibf[c] = 1'b0;
        if (en) begin
            if (wr) begin
                m_in[c] = d; m_ibf[c] = 1'b1; m_a0[c] = a0;
                e_ibf[c] = !m_ctrl[c][4] && (!m_ctrl[c][2] || a0);
            end else if (!a0) begin
                e_obe[c] = m_obf[c] && !m_ctrl[c][3];
                m_obf[c] = 1'b0;
            end
        end
        if (collide && !wr) begin m_out[c] = 8'h5A; m_obf[c] = 1'b1; end
        @(posedge clk); #1;
        e_obe[c] = 1'b0; e_ibf[c] = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_out[c] = 0; m_in[c] = 0; m_user[c] = 0; m_ctrl[c] = 0;
            m_obf[c] = 0; m_ibf[c] = 0; m_a0[c] = 0; e_obe[c] = 0; e_ibf[c] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        run = 1;
        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            sl_rd(c, 2'd1, "R1 status");
            sl_rd(c, 2'd2, "R1 ctrl");
        end
        chk("R1 doe", {7'd0, h_doe}, 8'd0);

        // R6 reserved control bit
        sl_wr(0, 2'd2, 8'h63);
        sl_rd(0, 2'd2, "R6 ctrl bit5");

        // R2 / R4 / R8 outbound path
        sl_wr(0, 2'd0, 8'hA5);
        sl_rd(0, 2'd1, "R2 status after fill");
        host_acc(0, 0, 1, 8'h00, 0, "R4 status read");
        sl_rd(0, 2'd1, "R4 obf kept");
        host_acc(0, 0, 0, 8'h00, 0, "R2 data read");
        sl_rd(0, 2'd1, "R2 obf cleared");

        // R3 inbound path and A0 capture
        host_acc(0, 1, 0, 8'h3C, 0, "R3 data write");
        sl_rd(0, 2'd1, "R3 status ibf");
        sl_rd(0, 2'd0, "R3 inbound byte");
        sl_rd(0, 2'd1, "R3 ibf cleared");
        host_acc(0, 1, 1, 8'h81, 0, "R3 cmd write");
        sl_rd(0, 2'd1, "R3 a0 flag");
        sl_rd(0, 2'd0, "R3 cmd byte");

        // R7 command filter and disable
        sl_wr(0, 2'd2, 8'h47);
        host_acc(0, 1, 0, 8'h12, 0, "R7 filtered data write");
        sl_rd(0, 2'd0, "R7 drain");
        host_acc(0, 1, 1, 8'h34, 0, "R7 cmd write irq");
        sl_wr(0, 2'd2, 8'h5F);
        host_acc(0, 1, 1, 8'h56, 0, "R7 irq disabled");
        // R8 disable
        sl_wr(0, 2'd0, 8'h11);
        host_acc(0, 0, 0, 8'h00, 0, "R8 irq disabled");

        // R11 flag pins off
        sl_wr(0, 2'd2, 8'h40);
        sl_wr(0, 2'd0, 8'h22);
        host_acc(0, 0, 0, 8'h00, 0, "R11 pins off");

        // R5 user flags
        sl_wr(0, 2'd1, 8'hFF);
        sl_rd(0, 2'd1, "R5 user via slave");
        host_acc(0, 0, 1, 8'h00, 0, "R5 user via master");

        // R9 / R12 combined strobe on channel 1
        sl_wr(1, 2'd2, 8'hC3);
        sl_wr(1, 2'd0, 8'h99);
        host_acc(1, 0, 0, 8'h00, 0, "R9 rw read");
        host_acc(1, 1, 1, 8'h6E, 0, "R9 rw write");
        sl_rd(1, 2'd1, "R9 status");
        sl_rd(1, 2'd0, "R9 inbound");
        sl_rd(0, 2'd1, "R12 other channel");
        sl_rd(0, 2'd3, "R12 unused addr");

        // R10 bus disabled
        sl_wr(0, 2'd2, 8'h03);
        host_acc(0, 1, 0, 8'hEE, 0, "R10 write ignored");
        host_acc(0, 0, 1, 8'h00, 0, "R10 read ignored");
        sl_rd(0, 2'd1, "R10 status");
        sl_rd(0, 2'd0, "R10 inbound kept");

        // R14 collisions
        sl_wr(0, 2'd2, 8'h43);
        sl_wr(0, 2'd0, 8'h10);
        host_acc(0, 0, 0, 8'h00, 1, "R14 fill vs drain");
        sl_rd(0, 2'd1, "R14 obf kept");
        host_acc(0, 1, 0, 8'h77, 1, "R14 write vs read");
        sl_rd(0, 2'd1, "R14 ibf kept");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule